// File: doc/BRIEF.md
# Selectable Frame Clock Generator

This block derives the frame-rate timing of a segment display driver from one reference. The reference is either a clock-enable pulse from a fast on-chip oscillator or a slow clock arriving on a pin, which the block synchronises and edge-detects. A 3-bit rate code picks one of eight frame rates spaced 32 Hz apart, from 32 Hz to 256 Hz. The block emits a one-cycle frame pulse for the waveform sequencer.

The block also drives a square-wave copy of the on-chip reference back onto the clock pin, with an output enable for the pad. It flags a missing clock when it is fed from the pin and no edges arrive. The register bank supplies the oscillator-off bit, the clock-output enable, the display enable and the rate code.

With the default base of 1024 reference ticks per 32 Hz frame (a 32768 Hz reference), the frame length for code c is 1024/(c+1) rounded to the nearest integer.

Top module: `frame_clk_gen`

## Requirements
- R1: A frame lasts round(BASE_TICKS/(code+1)) reference ticks: with the default base, codes 0 to 7 give 1024, 512, 341, 256, 205, 171, 146 and 128 ticks. `frame_tick` is a one-cycle pulse issued in the cycle after the tick that completes the frame.
- R2: After reset, `frame_tick`, `clk_pin_o`, `clk_pin_oe` and `clk_missing` are all 0.
- R3: A change of `frame_sel` takes effect only at the next frame boundary. The frame in progress completes at the length of the code that was active when it began, whether the new frame is shorter or longer.
- R4: With `osc_off` = 0, the reference is `osc_tick`, and activity on `clk_pin_i` has no effect on frame timing.
- R5: With `osc_off` = 1 and `clkout_en` = 0, each rising edge of `clk_pin_i` is one reference tick, taken after a two-flop synchroniser. `osc_tick` has no effect in this mode.
- R6: `clk_pin_oe` is 1 exactly when `disp_en` = 1, `osc_off` = 0 and `clkout_en` = 1. `clk_pin_o` is 0 whenever the enable is low.
- R7: While the pin is driven, `clk_pin_o` toggles once for each `osc_tick`, so its high and low phases each last exactly one tick interval (50 % duty).
- R8: While `disp_en` = 0, no frame pulse is issued and the divider is cleared. After re-enabling, the first frame is a full frame.
- R9: In pin-reference mode with `disp_en` = 1, `clk_missing` rises once MISS_TIMEOUT clock cycles pass without a synchronised pin edge. It clears on the next edge, or when leaving that mode or power-on.
- R10: With `osc_off` = 1 and `clkout_en` = 1, there is no reference: no frame pulse is issued and the pin is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_tick | input | 1 | On-chip reference clock-enable pulse |
| clk_pin_i | input | 1 | Clock pin input value (asynchronous) |
| osc_off | input | 1 | 1 = on-chip reference disabled |
| clkout_en | input | 1 | 1 = request reference on clock pin |
| disp_en | input | 1 | Display enable (0 = power-down) |
| frame_sel | input | CODE_W | Frame rate code |
| frame_tick | output | 1 | One-cycle frame boundary pulse |
| clk_pin_o | output | 1 | Clock pin output value |
| clk_pin_oe | output | 1 | Clock pin output enable |
| clk_missing | output | 1 | Pin reference lost |

## Verification
The assertions rely on `osc_tick` being a single-cycle pulse source, and on the pin clock being slow enough that at most one synchronised edge falls in any two adjacent cycles. The stimulus drives the pin with an eight-cycle period, which keeps it inside that limit.

Configuration changes that switch the reference source are made only while the display is disabled and the pin is held low. This keeps the bench's tick count and the synchroniser latency aligned. Rate codes are changed mid-frame only to exercise the boundary rule.

// File: rtl/fcg_pkg.sv
// Shared types and helpers for the frame clock generator.
// Assumes: codes index rates 1..2^CODE_W times the base rate.
package fcg_pkg;

    typedef enum logic [1:0] {
        SRC_INTERNAL = 2'd0,
        SRC_EXTERNAL = 2'd1,
        SRC_NONE     = 2'd2
    } ref_src_e;

    // Frame length in reference ticks for a code, rounded to nearest.
    function automatic int unsigned frame_len_f(input int unsigned base,
                                                input int unsigned code);
        int unsigned div;
        div = code + 1;
        return (base + div / 2) / div;
    endfunction

endpackage

// File: rtl/fcg_ref_select.sv
// Reference selection: synchronises the clock pin, detects its rising
// edges and chooses the on-chip tick, the pin edge or nothing.
// Assumes: osc_tick is already synchronous to clk.
module fcg_ref_select
    import fcg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     osc_off,
    input  logic     clkout_en,
    input  logic     osc_tick,
    input  logic     pin_in,
    output logic     ref_tick,
    output logic     ext_edge,
    output ref_src_e src
);

    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] sh;

    // Purpose: synchroniser chain plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[SH_W-2:0], pin_in};
    end

    assign ext_edge = sh[SH_W-2] & ~sh[SH_W-1];

    // Purpose: decode the reference source from the configuration bits.
    always_comb begin
        if (!osc_off)       src = SRC_INTERNAL;
        else if (!clkout_en) src = SRC_EXTERNAL;
        else                src = SRC_NONE;
    end

    // Purpose: route the selected reference to the divider.
    always_comb begin
        unique case (src)
            SRC_INTERNAL: ref_tick = osc_tick;
            SRC_EXTERNAL: ref_tick = ext_edge;
            default:      ref_tick = 1'b0;
        endcase
    end

    // R5: a synchronised pin edge never repeats in adjacent cycles
    assert_pin_tick_spaced_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_EXTERNAL && $past(src) == SRC_EXTERNAL && $past(ref_tick))
        |-> !ref_tick);

endmodule

// File: rtl/fcg_frame_div.sv
// Frame divider: counts reference ticks and pulses at each frame end.
// A new rate code is latched only at a boundary or while stopped.
// Assumes: ref_tick is a single-cycle enable.
module fcg_frame_div
    import fcg_pkg::*;
#(
    parameter int BASE_TICKS   = 1024,
    parameter int CODE_W       = 3,
    parameter int DEFAULT_CODE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              ref_tick,
    input  logic [CODE_W-1:0] code,
    output logic              frame_tick
);

    localparam int NCODES = 1 << CODE_W;
    localparam int CNT_W  = $clog2(BASE_TICKS + 1);

    logic [CNT_W-1:0] len_tab [NCODES];
    logic [CNT_W-1:0] len_sel;
    logic [CNT_W-1:0] cur_len;
    logic [CNT_W-1:0] cnt;

    // One length per code, computed at elaboration.
    for (genvar g = 0; g < NCODES; g++) begin : g_len
        assign len_tab[g] = CNT_W'(frame_len_f(BASE_TICKS, g));
    end

    assign len_sel = len_tab[code];

    // Purpose: count ticks, pulse on frame end, latch next length there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            cur_len    <= CNT_W'(frame_len_f(BASE_TICKS, DEFAULT_CODE));
            frame_tick <= 1'b0;
        end else if (!run) begin
            cnt        <= '0;
            cur_len    <= len_sel;
            frame_tick <= 1'b0;
        end else begin
            frame_tick <= 1'b0;
            if (ref_tick) begin
                if (cnt == cur_len - 1'b1) begin
                    cnt        <= '0;
                    cur_len    <= len_sel;
                    frame_tick <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R1: count stays inside the active frame
    assert_cnt_in_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < cur_len);

    // R1: every frame pulse follows a consumed tick
    assert_tick_caused_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick |-> $past(ref_tick));

    // R3: active length only moves at a boundary or while stopped
    assert_len_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(run) && !frame_tick) |-> $stable(cur_len));

    // R8: no frame pulse after a stopped cycle
    assert_quiet_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !frame_tick);

endmodule

// File: rtl/fcg_clk_monitor.sv
// Loss detector: raises a flag when the pin reference shows no edge for
// TIMEOUT cycles while watched.
// Assumes: watch is high only in pin-reference mode with display on.
module fcg_clk_monitor #(
    parameter int TIMEOUT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic watch,
    input  logic ext_edge,
    output logic missing
);

    localparam int CW = $clog2(TIMEOUT + 1);

    logic [CW-1:0] idle_cnt;

    // Purpose: measure idle time since the last edge, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !watch || ext_edge) begin
            idle_cnt <= '0;
            missing  <= 1'b0;
        end else begin
            if (idle_cnt != CW'(TIMEOUT)) idle_cnt <= idle_cnt + 1'b1;
            if (idle_cnt == CW'(TIMEOUT - 1)) missing <= 1'b1;
        end
    end

    // R9: an edge always clears the flag
    assert_edge_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ext_edge |=> !missing);

    // R9: flag drops when the pin is not being watched
    assert_unwatched_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !watch |=> !missing);

endmodule

// File: rtl/fcg_clk_out.sv
// Clock output stage: toggles once per on-chip tick while driving, so
// high and low phases are equal; holds low otherwise.
// Assumes: drive_en already includes power-on and mode qualification.
module fcg_clk_out (
    input  logic clk,
    input  logic rst_n,
    input  logic drive_en,
    input  logic osc_tick,
    output logic pin_out,
    output logic pin_oe
);

    logic q;

    // Purpose: divide-by-two toggle flop, cleared while not driving.
    always_ff @(posedge clk) begin
        if (!rst_n)         q <= 1'b0;
        else if (!drive_en) q <= 1'b0;
        else if (osc_tick)  q <= ~q;
    end

    assign pin_out = q;
    assign pin_oe  = drive_en;

    // R6: output settles low once the enable drops
    assert_low_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_en |=> !pin_out);

    // R7: output only changes phase on a tick
    assert_phase_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && drive_en && $past(drive_en) && !$past(osc_tick))
        |-> $stable(pin_out));

endmodule

// File: rtl/frame_clk_gen.sv
// Frame clock generator top: selects the reference, divides it to the
// chosen frame rate, drives the clock pin and watches for a lost pin clock.
// Assumes: configuration inputs come from synchronous register flops.
module frame_clk_gen
    import fcg_pkg::*;
#(
    parameter int BASE_TICKS   = 1024,
    parameter int CODE_W       = 3,
    parameter int DEFAULT_CODE = 1,
    parameter int SYNC_STAGES  = 2,
    parameter int MISS_TIMEOUT = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_tick,
    input  logic              clk_pin_i,
    input  logic              osc_off,
    input  logic              clkout_en,
    input  logic              disp_en,
    input  logic [CODE_W-1:0] frame_sel,
    output logic              frame_tick,
    output logic              clk_pin_o,
    output logic              clk_pin_oe,
    output logic              clk_missing
);

    logic     ref_tick;
    logic     ext_edge;
    ref_src_e src;
    logic     watch;
    logic     drive_en;

    assign watch    = disp_en && (src == SRC_EXTERNAL);
    assign drive_en = disp_en && (src == SRC_INTERNAL) && clkout_en;

    fcg_ref_select #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_ref (
        .clk       (clk),
        .rst_n     (rst_n),
        .osc_off   (osc_off),
        .clkout_en (clkout_en),
        .osc_tick  (osc_tick),
        .pin_in    (clk_pin_i),
        .ref_tick  (ref_tick),
        .ext_edge  (ext_edge),
        .src       (src)
    );

    fcg_frame_div #(
        .BASE_TICKS   (BASE_TICKS),
        .CODE_W       (CODE_W),
        .DEFAULT_CODE (DEFAULT_CODE)
    ) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (disp_en),
        .ref_tick   (ref_tick),
        .code       (frame_sel),
        .frame_tick (frame_tick)
    );

    fcg_clk_out u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .drive_en (drive_en),
        .osc_tick (osc_tick),
        .pin_out  (clk_pin_o),
        .pin_oe   (clk_pin_oe)
    );

    fcg_clk_monitor #(
        .TIMEOUT (MISS_TIMEOUT)
    ) u_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .watch    (watch),
        .ext_edge (ext_edge),
        .missing  (clk_missing)
    );

    // R10: no reference configuration yields no frame pulse
    assert_no_ref_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_off && clkout_en && $past(osc_off && clkout_en)) |-> !frame_tick);

endmodule

// File: tb/frame_clk_gen_bench.sv
`timescale 1ns/1ps
module frame_clk_gen_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       osc_tick;
    logic       clk_pin_i;
    logic       osc_off;
    logic       clkout_en;
    logic       disp_en;
    logic [2:0] frame_sel;
    logic       frame_tick;
    logic       clk_pin_o;
    logic       clk_pin_oe;
    logic       clk_missing;

    int n_checks = 0;
    int n_fail   = 0;
    int stray    = 0;
    int mon_cnt  = 0;
    int tick_gap = 0;
    bit pin_run  = 0;
    bit sb_on    = 0;
    bit pin_prev = 0;
    string cur_req = "R1";
    int exp_q[$];

    always #2.5 clk = ~clk;

    frame_clk_gen #(.MISS_TIMEOUT(64)) u_frame_clk_gen (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .clk_pin_i(clk_pin_i),
        .osc_off(osc_off), .clkout_en(clkout_en), .disp_en(disp_en),
        .frame_sel(frame_sel), .frame_tick(frame_tick), .clk_pin_o(clk_pin_o),
        .clk_pin_oe(clk_pin_oe), .clk_missing(clk_missing)
    );

    // Expected frame length, from the requirement's rounding rule.
    function automatic int exp_len(input int c);
        return (2 * 1024 + (c + 1)) / (2 * (c + 1));
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // On-chip tick source: one pulse every tick_gap cycles.
    int gcnt = 0;
    always @(negedge clk) begin
        if (tick_gap == 0) begin
            osc_tick = 1'b0; gcnt = 0;
        end else if (gcnt >= tick_gap - 1) begin
            osc_tick = 1'b1; gcnt = 0;
        end else begin
            osc_tick = 1'b0; gcnt++;
        end
    end

    // Pin clock source: period of eight cycles.
    int pcnt = 0;
    always @(negedge clk) begin
        if (!pin_run) begin
            clk_pin_i = 1'b0; pcnt = 0;
        end else begin
            pcnt = (pcnt + 1) % 8;
            clk_pin_i = (pcnt >= 4);
        end
    end

    // Monitor: counts consumed ticks, pops and compares on each frame pulse.
    always @(posedge clk) begin
        bit rise;
        int e;
        #1;
        rise = clk_pin_i && !pin_prev;
        pin_prev = clk_pin_i;
        if (!rst_n || !disp_en) mon_cnt = 0;
        else if (!osc_off && osc_tick) mon_cnt++;
        else if (osc_off && !clkout_en && rise) mon_cnt++;
        if (frame_tick) begin
            if (sb_on) begin
                if (exp_q.size() == 0) begin
                    stray++;
                    check(1'b0, "R8 R10 unexpected frame", mon_cnt, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(mon_cnt == e, cur_req, mon_cnt, e);
                end
            end
            mon_cnt = 0;
        end
    end

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog: a hang counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        int s0;
        int run_len;
        bit v;
        rst_n = 1'b0; osc_off = 1'b0; clkout_en = 1'b0; disp_en = 1'b0;
        frame_sel = 3'd1; osc_tick = 1'b0; clk_pin_i = 1'b0;
        repeat (4) @(negedge clk);
        // R2: reset state
        check(frame_tick == 0, "R2 frame_tick", frame_tick, 0);
        check(clk_pin_o == 0, "R2 clk_pin_o", clk_pin_o, 0);
        check(clk_pin_oe == 0, "R2 clk_pin_oe", clk_pin_oe, 0);
        check(clk_missing == 0, "R2 clk_missing", clk_missing, 0);
        rst_n = 1'b1;

        // R1 R4: all codes, tick each cycle, pin toggling as noise
        sb_on = 1; tick_gap = 1; pin_run = 1; cur_req = "R1 R4 sweep";
        for (int c = 0; c < 8; c++) begin
            disp_en = 0; frame_sel = 3'(c);
            repeat (2) @(negedge clk);
            exp_q.push_back(exp_len(c)); exp_q.push_back(exp_len(c));
            disp_en = 1;
            drain();
            disp_en = 0;
        end

        // R1: sparse ticks, every third cycle
        tick_gap = 3; cur_req = "R1 sparse";
        for (int c = 2; c < 8; c += 3) begin
            disp_en = 0; frame_sel = 3'(c);
            repeat (4) @(negedge clk);
            exp_q.push_back(exp_len(c)); exp_q.push_back(exp_len(c));
            disp_en = 1;
            drain();
            disp_en = 0;
        end

        // R3: long frame switched to short mid-frame is not shortened
        tick_gap = 1; cur_req = "R3 long->short";
        frame_sel = 3'd0; repeat (3) @(negedge clk);
        exp_q.push_back(1024); exp_q.push_back(128); exp_q.push_back(128);
        disp_en = 1;
        while (mon_cnt < 300) @(negedge clk);
        frame_sel = 3'd7;
        drain();
        disp_en = 0;

        // R3: short frame switched to long mid-frame
        cur_req = "R3 short->long";
        repeat (3) @(negedge clk);
        exp_q.push_back(128); exp_q.push_back(1024);
        disp_en = 1;
        while (mon_cnt < 50) @(negedge clk);
        frame_sel = 3'd0;
        drain();
        disp_en = 0;

        // R8: power-down aborts a frame; re-enable restarts a full one
        cur_req = "R8 restart";
        frame_sel = 3'd2; repeat (3) @(negedge clk);
        disp_en = 1;
        while (mon_cnt < 200) @(negedge clk);
        disp_en = 0;
        s0 = stray;
        repeat (400) @(negedge clk);
        check(stray == s0, "R8 quiet while off", stray, s0);
        exp_q.push_back(341);
        disp_en = 1;
        drain();
        disp_en = 0;

        // R6 R7: clock output driven from the on-chip reference
        sb_on = 0; tick_gap = 3; clkout_en = 1; osc_off = 0;
        @(negedge clk);
        check(clk_pin_oe == 0, "R6 oe off in power-down", clk_pin_oe, 0);
        disp_en = 1;
        @(negedge clk);
        check(clk_pin_oe == 1, "R6 oe on", clk_pin_oe, 1);
        v = clk_pin_o;
        while (clk_pin_o == v) @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            v = clk_pin_o; run_len = 0;
            while (clk_pin_o == v) begin @(negedge clk); run_len++; end
            check(run_len == 3, "R7 phase length", run_len, 3);
        end
        disp_en = 0;
        @(negedge clk);
        check(clk_pin_oe == 0, "R6 oe drops", clk_pin_oe, 0);
        check(clk_pin_o == 0, "R6 out low", clk_pin_o, 0);
        disp_en = 1; clkout_en = 0;
        repeat (2) @(negedge clk);
        check(clk_pin_oe == 0, "R6 oe off when not requested", clk_pin_oe, 0);
        disp_en = 0;

        // R5: pin reference, on-chip ticks still running and ignored
        pin_run = 0; tick_gap = 1; osc_off = 1; clkout_en = 0;
        frame_sel = 3'd7; cur_req = "R5 pin reference";
        repeat (4) @(negedge clk);
        sb_on = 1;
        exp_q.push_back(128); exp_q.push_back(128);
        disp_en = 1;
        @(negedge clk);
        pin_run = 1;
        drain();
        check(clk_pin_oe == 0, "R6 oe off in pin mode", clk_pin_oe, 0);

        // R9: pin clock lost and restored
        sb_on = 0;
        pin_run = 0;
        repeat (20) @(negedge clk);
        check(clk_missing == 0, "R9 not yet missing", clk_missing, 0);
        repeat (80) @(negedge clk);
        check(clk_missing == 1, "R9 missing raised", clk_missing, 1);
        pin_run = 1;
        repeat (20) @(negedge clk);
        check(clk_missing == 0, "R9 cleared by edge", clk_missing, 0);
        pin_run = 0;
        repeat (100) @(negedge clk);
        disp_en = 0;
        repeat (2) @(negedge clk);
        check(clk_missing == 0, "R9 cleared by power-down", clk_missing, 0);

        // R10: no reference configuration
        clkout_en = 1; osc_off = 1; pin_run = 1; tick_gap = 1;
        repeat (3) @(negedge clk);
        sb_on = 1; s0 = stray;
        disp_en = 1;
        repeat (2000) @(negedge clk);
        check(stray == s0, "R10 no frame pulse", stray, s0);
        check(clk_pin_oe == 0, "R10 pin not driven", clk_pin_oe, 0);
        disp_en = 0;
        repeat (3) @(negedge clk);

        finish_run();
    end

endmodule